// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous Static Memory

This block is a single-port synchronous static memory for a cache-style data store. One input register stage captures the address, the write data and the decoded access on the rising clock edge. Three write inputs are decoded into a per-lane write mask: a global strobe, a write enable and one strobe for each 9-bit lane. The array writes itself one edge later, so the caller never has to shape a write pulse.

Reads go through an edge-triggered output register. Data for an access sampled at edge t is on the bus after edge t+1. The output drivers stay on for one more cycle after the block stops reading. The output-enable and sleep inputs act at once, without waiting for a clock edge. Sleep also turns every access it sees into an idle cycle, and the array keeps its contents.

The word is made of `LANES` lanes of 9 bits: four lanes (36 bits) by default, or two lanes (18 bits) for the narrow variant. The depth is a parameter. The pad drivers sit outside the block. `q_en` is their enable. While it is low the bus is high impedance and `q` reads zero.

Top module: `pipe_bw_sram`

## Requirements
- R1: A cycle sampled with `ce`=1, `sleep`=0 and `glob_we`=1 writes all lanes of `wdata` to `addr`, whatever `lane_we` and `wr_en` are.
- R2: With `glob_we`=0 and `wr_en`=1, only the lanes whose `lane_we` bit is set are written. Bit l of `lane_we` gates `wdata[9l+8:9l]`, and the other lanes keep their contents.
- R3: `wr_en`=1 together with every `lane_we` bit set writes the whole word.
- R4: With `glob_we`=0 and `wr_en`=0 the cycle is a read: the `lane_we` bits have no effect and memory is unchanged.
- R5: For a read sampled at rising edge t, the stored word is on `q` with `q_en`=1 after edge t+1 and before edge t+2.
- R6: Once reads stop, the drivers stay on for one more cycle. If the last read is sampled at edge t and a deselect, write or sleep cycle at t+1, then `q_en` is 1 after edges t+1 and t+2 and 0 after edge t+3.
- R7: `q_en` = 0 as soon as `oe` is 0, without waiting for a clock edge. Whenever `q_en` is 0, `q` is all zeros.
- R8: While `sleep`=1, `q_en` is 0 at once, sampled accesses become idle cycles, writes are dropped, and stored data is kept for the reads that follow.
- R9: A write sampled at edge t followed by a read of the same address sampled at edge t+1 returns the newly written data.
- R10: While `rst_n` is 0, `q_en` is 0 and `q` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | AW = log2(DEPTH) | Word address (from an external burst sequencer) |
| ce | input | 1 | Chip enable, 1 = access this cycle |
| lane_we | input | LANES | Per-lane byte write strobes |
| glob_we | input | 1 | Global write strobe, writes all lanes |
| wr_en | input | 1 | Write enable, qualifies `lane_we` |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep: blocks accesses, turns drivers off |
| wdata | input | 9*LANES | Write data |
| q | output | 9*LANES | Read data, zero when not driven |
| q_en | output | 1 | Pad driver enable, 0 = bus high impedance |

## Verification
The hardest state to reach from the ports is the extended drive window that overlaps other traffic: a read whose data stays on the bus while the next cycle is a deselect, or a write, or while `oe` or `sleep` changes between two edges. The stimulus puts back-to-back read, deselect and write cycles in a row. It also changes `oe` and `sleep` a few nanoseconds after an edge, while the driver window is open. A behavioural reference model is compared with the ports at every clock, lane by lane, and only on lanes that have been written.

// File: rtl/psram_pkg.sv
package psram_pkg;

   localparam int LANE_W = 9;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bw_decode.sv
module bw_decode
   import psram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             ce,
   input  logic             sleep,
   input  logic [LANES-1:0] lane_we,
   input  logic             glob_we,
   input  logic             wr_en,
   output acc_e             kind,
   output logic [LANES-1:0] mask
);

   logic sel;
   logic is_wr;

   assign sel   = ce & ~sleep;
   assign is_wr = glob_we | wr_en;

   always_comb begin
      kind = ACC_IDLE;
      mask = '0;
      if (sel) begin
         if (is_wr) begin
            kind = ACC_WRITE;
            mask = glob_we ? {LANES{1'b1}} : lane_we;
         end else begin
            kind = ACC_READ;
         end
      end
   end

endmodule

// File: rtl/bw_in_stage.sv
module bw_in_stage
   import psram_pkg::*;
#(
   parameter int LANES = 4,
   parameter int AW    = 8,
   localparam int DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_e             kind_i,
   input  logic [LANES-1:0] mask_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    data_i,
   output acc_e             kind_q,
   output logic [LANES-1:0] mask_q,
   output logic [AW-1:0]    addr_q,
   output logic [DW-1:0]    data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= ACC_IDLE;
         mask_q <= '0;
      end else begin
         kind_q <= kind_i;
         mask_q <= mask_i;
      end
   end

   always_ff @(posedge clk) begin
      addr_q <= addr_i;
      data_q <= data_i;
   end

endmodule

// File: rtl/bw_lane_array.sv
module bw_lane_array
   import psram_pkg::*;
#(
   parameter int LANES = 4,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  acc_e             kind_q,
   input  logic [LANES-1:0] mask_q,
   input  logic [AW-1:0]    addr_q,
   input  logic [DW-1:0]    data_q,
   output logic [DW-1:0]    rd_word
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic              lane_wr;

      assign lane_wr = (kind_q == ACC_WRITE) & mask_q[l];

      always_ff @(posedge clk) begin
         if (lane_wr) mem[addr_q] <= data_q[l*LANE_W +: LANE_W];
      end

      assign rd_word[l*LANE_W +: LANE_W] = mem[addr_q];
   end

endmodule

// File: rtl/bw_out_stage.sv
module bw_out_stage
   import psram_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DW   = LANES * LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  acc_e          kind_q,
   input  logic [DW-1:0] rd_word,
   input  logic          oe,
   input  logic          sleep,
   output logic [DW-1:0] q,
   output logic          q_en
);

   logic [DW-1:0] out_q;
   logic          drive_q;
   logic          hold_q;
   logic          rd_now;

   assign rd_now = (kind_q == ACC_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         drive_q <= rd_now;
         hold_q  <= drive_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_now) out_q <= rd_word;
   end

   assign q_en = (drive_q | hold_q) & oe & ~sleep;
   assign q    = q_en ? out_q : '0;

   // R5
   lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_q |-> $past(kind_q == ACC_READ));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(kind_q == ACC_READ) |=> hold_q);

endmodule

// File: rtl/pipe_bw_sram.sv
module pipe_bw_sram
   import psram_pkg::*;
#(
   parameter int LANES = 4,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             ce,
   input  logic [LANES-1:0] lane_we,
   input  logic             glob_we,
   input  logic             wr_en,
   input  logic             oe,
   input  logic             sleep,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    q,
   output logic             q_en
);

   if (!(LANES == 2 || LANES == 4)) begin : g_bad_lanes
      $error("pipe_bw_sram: LANES must be 2 or 4");
   end
   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("pipe_bw_sram: DEPTH must be a power of two of at least 2");
   end

   acc_e             dec_kind;
   logic [LANES-1:0] dec_mask;
   acc_e             st_kind;
   logic [LANES-1:0] st_mask;
   logic [AW-1:0]    st_addr;
   logic [DW-1:0]    st_data;
   logic [DW-1:0]    rd_word;

   bw_decode #(.LANES(LANES)) u_dec (
      .ce      (ce),
      .sleep   (sleep),
      .lane_we (lane_we),
      .glob_we (glob_we),
      .wr_en   (wr_en),
      .kind    (dec_kind),
      .mask    (dec_mask)
   );

   bw_in_stage #(.LANES(LANES), .AW(AW)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind_i (dec_kind),
      .mask_i (dec_mask),
      .addr_i (addr),
      .data_i (wdata),
      .kind_q (st_kind),
      .mask_q (st_mask),
      .addr_q (st_addr),
      .data_q (st_data)
   );

   bw_lane_array #(.LANES(LANES), .DEPTH(DEPTH)) u_arr (
      .clk     (clk),
      .kind_q  (st_kind),
      .mask_q  (st_mask),
      .addr_q  (st_addr),
      .data_q  (st_data),
      .rd_word (rd_word)
   );

   bw_out_stage #(.LANES(LANES)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind_q  (st_kind),
      .rd_word (rd_word),
      .oe      (oe),
      .sleep   (sleep),
      .q       (q),
      .q_en    (q_en)
   );

   // R1
   glob_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !sleep && glob_we) |=> (st_kind == ACC_WRITE && st_mask == {LANES{1'b1}}));

   // R8
   sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (st_kind == ACC_IDLE));

endmodule

// File: tb/pipe_bw_sram_test.sv
module pipe_bw_sram_test;

   localparam int LANES = 4;
   localparam int LW    = 9;
   localparam int DW    = LANES * LW;
   localparam int DEPTH = 256;
   localparam int AW    = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n   = 1'b0;
   logic [AW-1:0]    addr    = '0;
   logic             ce      = 1'b0;
   logic [LANES-1:0] lane_we = '0;
   logic             glob_we = 1'b0;
   logic             wr_en   = 1'b0;
   logic             oe      = 1'b1;
   logic             sleep   = 1'b0;
   logic [DW-1:0]    wdata   = '0;
   logic [DW-1:0]    q;
   logic             q_en;

   pipe_bw_sram #(.LANES(LANES), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce(ce), .lane_we(lane_we),
      .glob_we(glob_we), .wr_en(wr_en), .oe(oe), .sleep(sleep),
      .wdata(wdata), .q(q), .q_en(q_en)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   string phase    = "R10";
   bit    ended    = 1'b0;

   // behavioural reference: 0 idle, 1 read, 2 write
   logic [DW-1:0]    mdl_mem  [DEPTH];
   logic [LANES-1:0] mdl_kn   [DEPTH];
   int               s_kind = 0;
   logic [LANES-1:0] s_mask;
   logic [AW-1:0]    s_addr;
   logic [DW-1:0]    s_data;
   bit               e_drive = 0, e_hold = 0;
   logic [DW-1:0]    e_out = '0;
   logic [LANES-1:0] e_known = '0;

   initial for (int i = 0; i < DEPTH; i++) mdl_kn[i] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         s_kind = 0; e_drive = 0; e_hold = 0;
      end else begin
         e_hold  = e_drive;
         e_drive = (s_kind == 1);
         if (s_kind == 1) begin
            e_out   = mdl_mem[s_addr];
            e_known = mdl_kn[s_addr];
         end
         if (s_kind == 2)
            for (int l = 0; l < LANES; l++)
               if (s_mask[l]) begin
                  mdl_mem[s_addr][l*LW +: LW] = s_data[l*LW +: LW];
                  mdl_kn[s_addr][l] = 1'b1;
               end
         s_addr = addr;
         s_data = wdata;
         if (ce && !sleep) begin
            if (glob_we) begin s_kind = 2; s_mask = '1; end
            else if (wr_en) begin s_kind = 2; s_mask = lane_we; end
            else begin s_kind = 1; s_mask = '0; end
         end else begin
            s_kind = 0; s_mask = '0;
         end
      end
   end

   task automatic compare_ports();
      bit exp_en;
      exp_en = (e_drive || e_hold) && oe && !sleep && rst_n;
      n_checks++;
      if (q_en !== exp_en) begin
         n_fail++;
         $display("FAIL %s q_en=%b exp=%b at %0t", phase, q_en, exp_en, $time);
      end
      if (exp_en) begin
         for (int l = 0; l < LANES; l++)
            if (e_known[l]) begin
               n_checks++;
               if (q[l*LW +: LW] !== e_out[l*LW +: LW]) begin
                  n_fail++;
                  $display("FAIL %s lane %0d q=%h exp=%h at %0t", phase, l,
                           q[l*LW +: LW], e_out[l*LW +: LW], $time);
               end
            end
      end else begin
         n_checks++;
         if (q !== '0) begin
            n_fail++;
            $display("FAIL %s undriven q=%h exp=0 at %0t", phase, q, $time);
         end
      end
   endtask

   always @(negedge clk) if (!ended) compare_ports();

   task automatic expect_en(input string req, input bit exp);
      n_checks++;
      if (q_en !== exp) begin
         n_fail++;
         $display("FAIL %s q_en=%b exp=%b at %0t", req, q_en, exp, $time);
      end
   endtask

   task automatic op(input bit c, input int a, input logic [LANES-1:0] lw,
                     input bit g, input bit w, input logic [DW-1:0] d);
      @(posedge clk);
      #2;
      ce = c; addr = AW'(a); lane_we = lw; glob_we = g; wr_en = w; wdata = d;
   endtask

   task automatic rd(input int a);
      op(1'b1, a, '0, 1'b0, 1'b0, '0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(1'b0, 0, '0, 1'b0, 1'b0, '0);
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int k);
      return {4{9'(a * 37 + k * 101)}} ^ {9'(k), 9'(a), 9'(a + k), 9'(3 * a)};
   endfunction

   task automatic finish_run();
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired, run hung");
      finish_run();
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      expect_en("R10", 1'b0);
      n_checks++;
      if (q !== '0) begin n_fail++; $display("FAIL R10 q=%h exp=0", q); end
      @(posedge clk); #2; rst_n = 1'b1;
      idle(2);

      phase = "R1";
      for (int a = 0; a < 32; a++) op(1'b1, a, 4'(a), 1'b1, a[0], pat(a, 1));
      idle(2);
      phase = "R5";
      for (int a = 0; a < 32; a++) rd(a);
      idle(3);

      phase = "R2";
      for (int a = 0; a < 16; a++) op(1'b1, a, 4'(a), 1'b0, 1'b1, pat(a, 2));
      idle(2);
      for (int a = 0; a < 16; a++) rd(a);
      idle(3);

      phase = "R3";
      for (int a = 40; a < 48; a++) op(1'b1, a, 4'hF, 1'b0, 1'b1, pat(a, 3));
      for (int a = 40; a < 48; a++) rd(a);
      idle(3);

      phase = "R4";
      for (int a = 0; a < 8; a++) op(1'b1, a, 4'hF, 1'b0, 1'b0, pat(a, 4));
      for (int a = 0; a < 8; a++) rd(a);
      idle(3);

      phase = "R9";
      for (int a = 60; a < 66; a++) begin
         op(1'b1, a, '0, 1'b1, 1'b0, pat(a, 9));
         rd(a);
      end
      idle(3);

      // R6: read, then deselect; drivers on for two sampling points, then off
      phase = "R6";
      rd(3);
      idle(1);
      @(negedge clk);
      @(negedge clk); expect_en("R6", 1'b1);
      @(negedge clk); expect_en("R6", 1'b1);
      @(negedge clk); expect_en("R6", 1'b0);
      rd(5);
      op(1'b1, 70, '0, 1'b1, 1'b0, pat(70, 6));
      rd(70);
      idle(4);

      // R7: asynchronous output enable
      phase = "R7";
      rd(5);
      idle(1);
      @(negedge clk);
      @(negedge clk);
      #1; oe = 1'b0;
      #1; expect_en("R7", 1'b0);
      n_checks++;
      if (q !== '0) begin n_fail++; $display("FAIL R7 q=%h exp=0", q); end
      oe = 1'b1;
      #1; expect_en("R7", 1'b1);
      idle(3);

      // R8: sleep blocks accesses and keeps contents
      phase = "R8";
      rd(6);
      idle(1);
      @(negedge clk);
      @(negedge clk);
      #1; sleep = 1'b1;
      #1; expect_en("R8", 1'b0);
      for (int a = 0; a < 8; a++) op(1'b1, a, 4'hF, 1'b1, 1'b1, pat(a, 8));
      for (int a = 0; a < 4; a++) rd(a);
      idle(1);
      @(posedge clk); #2; sleep = 1'b0;
      idle(2);
      for (int a = 0; a < 8; a++) rd(a);
      idle(4);

      finish_run();
   end

endmodule